// File: doc/BRIEF.md
# Multi-Context Configuration Memory Command Sequencer

This block turns a 3-bit command, a context number and a supply-detector level into the timed control levels that a non-volatile, multi-context configuration memory needs. It drives four abstract lines: cell power, a wordline enable together with the context whose wordline/plateline pair it addresses, and two plateline levels. Each plateline level is encoded as 2'b00 low, 2'b01 half supply or 2'b10 high. Each operation is a short, fixed sequence of one-cycle steps. The block produces no analog sensing and has no cell array. It emits encoded control states only.

The state machine has ten named states. S_OFF is the unpowered rest state, and S_NORMAL is the powered standby state. The recall path runs S_RC_PRE, S_RC_PL1, S_RC_PWR and then S_NORMAL. A context change is S_READ, held for CTX_LAT cycles, and then S_NORMAL. Programming runs S_PG_HI, S_PG_LO and then S_NORMAL. The power-off path runs S_PO_PL, S_PO_CUT and then S_OFF.

The transitions are as follows. A recall request moves S_OFF to S_RC_PRE. In S_NORMAL, a context-change command moves to S_READ and a program command moves to S_PG_HI. Every recall, read and program state moves to S_PO_PL on a power-off request if cell power is on in that state, and to S_PO_CUT if it is off. Every other step advances unconditionally. A falling edge of the supply-detector input is a power-off request and a rising edge is a recall request. Commands 5 and 4 make the same requests.

Top module: `cfgseq_ctrl`

## Requirements
- R1: After reset the block is in S_OFF. cell_pwr, wl_en, busy and done are 0, both platelines are low (2'b00) and active_ctx is 0.
- R2: A recall request in S_OFF (supply_ok rising, or cmd 4 with cmd_valid) runs three steps. The first step has everything low and power off. The second has pl1 high, pl2 low and power off. The third has pl1 high, pl2 low and power on. The wordline stays low throughout, and the block then enters Normal.
- R3: In Normal, cell_pwr is 1, wl_en is 0, both platelines are at half supply (2'b01) and wl_ctx equals active_ctx.
- R4: cmd 2 (context change) accepted in Normal holds wl_en 1, cell_pwr 1 and both platelines at half for CTX_LAT cycles, with wl_ctx equal to the requested ctx_id. In the cycle that begins CTX_LAT clock edges after the accepting edge, active_ctx takes the new value and done pulses.
- R5: cmd 3 (program) accepted in Normal gives one step with wl_en 1 and both platelines high, then one step with wl_en 1 and both platelines low. wl_ctx equals the target context, and active_ctx does not change.
- R6: A power-off request in Normal (supply_ok falling, or cmd 5) gives one step with power on and both platelines low, then one step with power off. The block then enters S_OFF.
- R7: A power-off request pre-empts a running context change, program or recall. The pre-empted sequence raises no done and does not change active_ctx. A power-off request in S_OFF or during power-off is ignored.
- R8: busy is 1 exactly while a sequence step runs. Commands that arrive while busy are ignored, except a power-off request.
- R9: cmd 0 (none), 1 (shift-through), 6 and 7 (test), and cmd 4 while in Normal start no sequence and leave the outputs unchanged. cmd 2 and cmd 3 are ignored in S_OFF.
- R10: done is a single-cycle pulse. It is high in the first cycle after the final step of a completed sequence and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, sampled each clock edge |
| cmd | input | 3 | Command code: 0 none, 1 shift-through, 2 context change, 3 program, 4 recall, 5 power-off, 6/7 test |
| ctx_id | input | CTX_W | Target context for context change and program |
| supply_ok | input | 1 | Supply-detector level; rising edge requests recall, falling edge requests power-off |
| cell_pwr | output | 1 | Cell power enable |
| wl_en | output | 1 | Wordline enable |
| wl_ctx | output | CTX_W | Context whose wordline/plateline pair is addressed |
| pl1_lvl | output | 2 | Plateline 1 level (00 low, 01 half, 10 high) |
| pl2_lvl | output | 2 | Plateline 2 level (00 low, 01 half, 10 high) |
| active_ctx | output | CTX_W | Currently active context |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses CTX_W = 3 and CTX_LAT = 6. With these values every one of the eight contexts, including both extremes 0 and 7, can be reached as a context-change or program target. The six-cycle read window is long enough for a power-off to land in the middle of a context change. Random command codes are interleaved with supply drops and restores, so every state is entered both from its normal predecessor and, for power-off, from a pre-empted sequence.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    typedef enum logic [1:0] {
        PL_LOW  = 2'b00,
        PL_HALF = 2'b01,
        PL_HIGH = 2'b10
    } pl_lvl_e;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_SHIFT  = 3'd1,
        OP_CTX    = 3'd2,
        OP_PROG   = 3'd3,
        OP_RECALL = 3'd4,
        OP_PWROFF = 3'd5,
        OP_TEST0  = 3'd6,
        OP_TEST1  = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        S_OFF,
        S_RC_PRE,
        S_RC_PL1,
        S_RC_PWR,
        S_NORMAL,
        S_READ,
        S_PG_HI,
        S_PG_LO,
        S_PO_PL,
        S_PO_CUT
    } seq_state_e;

endpackage

// File: rtl/cfgseq_vdet.sv
module cfgseq_vdet (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise,
    output logic fall
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_in;
    end

    assign rise = level_in & ~level_q;
    assign fall = ~level_in & level_q;
endmodule

// File: rtl/cfgseq_timer.sv
module cfgseq_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/cfgseq_ctrl.sv
module cfgseq_ctrl #(
    parameter int CTX_W   = 3,
    parameter int CTX_LAT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd,
    input  logic [CTX_W-1:0] ctx_id,
    input  logic             supply_ok,
    output logic             cell_pwr,
    output logic             wl_en,
    output logic [CTX_W-1:0] wl_ctx,
    output logic [1:0]       pl1_lvl,
    output logic [1:0]       pl2_lvl,
    output logic [CTX_W-1:0] active_ctx,
    output logic             busy,
    output logic             done
);
    import cfgseq_pkg::*;

    localparam int              CNT_W   = (CTX_LAT > 1) ? $clog2(CTX_LAT) : 1;
    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(CTX_LAT - 1);

    seq_state_e       state_q, state_d;
    logic [CTX_W-1:0] tgt_q, act_q;
    logic             done_q;
    logic             sup_rise, sup_fall;
    logic             tmr_load, tmr_zero;
    logic             fin, capture, commit;
    logic             req_off, req_rec;
    logic             pwr_now;
    op_e              op;
    pl_lvl_e          pl1, pl2;

    assign op      = op_e'(cmd);
    assign req_off = sup_fall | (cmd_valid && op == OP_PWROFF);
    assign req_rec = sup_rise | (cmd_valid && op == OP_RECALL);

    cfgseq_vdet u_vdet (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (supply_ok),
        .rise     (sup_rise),
        .fall     (sup_fall)
    );

    cfgseq_timer #(.W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (RD_LAST),
        .zero     (tmr_zero)
    );

    // next-state decision
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        fin      = 1'b0;
        capture  = 1'b0;
        commit   = 1'b0;
        if (req_off && !(state_q inside {S_OFF, S_NORMAL, S_PO_PL, S_PO_CUT})) begin
            state_d = pwr_now ? S_PO_PL : S_PO_CUT;
        end else if (req_off && state_q == S_NORMAL) begin
            state_d = S_PO_PL;
        end else begin
            unique case (state_q)
                S_OFF:    if (req_rec) state_d = S_RC_PRE;
                S_RC_PRE: state_d = S_RC_PL1;
                S_RC_PL1: state_d = S_RC_PWR;
                S_RC_PWR: begin state_d = S_NORMAL; fin = 1'b1; end
                S_NORMAL: begin
                    if (cmd_valid) begin
                        case (op)
                            OP_CTX:  begin state_d = S_READ;  tmr_load = 1'b1; capture = 1'b1; end
                            OP_PROG: begin state_d = S_PG_HI; capture = 1'b1; end
                            default: state_d = S_NORMAL;
                        endcase
                    end
                end
                S_READ:   if (tmr_zero) begin state_d = S_NORMAL; fin = 1'b1; commit = 1'b1; end
                S_PG_HI:  state_d = S_PG_LO;
                S_PG_LO:  begin state_d = S_NORMAL; fin = 1'b1; end
                S_PO_PL:  state_d = S_PO_CUT;
                S_PO_CUT: begin state_d = S_OFF; fin = 1'b1; end
                default:  state_d = S_OFF;
            endcase
        end
    end

    // state register and sequence bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            tgt_q   <= '0;
            act_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= fin;
            if (capture) tgt_q <= ctx_id;
            if (commit)  act_q <= tgt_q;
        end
    end

    // output levels per state
    always_comb begin
        pwr_now = 1'b0;
        wl_en   = 1'b0;
        pl1     = PL_LOW;
        pl2     = PL_LOW;
        wl_ctx  = act_q;
        unique case (state_q)
            S_OFF, S_RC_PRE, S_PO_CUT: ;
            S_RC_PL1: pl1 = PL_HIGH;
            S_RC_PWR: begin pwr_now = 1'b1; pl1 = PL_HIGH; end
            S_NORMAL: begin pwr_now = 1'b1; pl1 = PL_HALF; pl2 = PL_HALF; end
            S_READ:   begin pwr_now = 1'b1; wl_en = 1'b1; pl1 = PL_HALF; pl2 = PL_HALF; wl_ctx = tgt_q; end
            S_PG_HI:  begin pwr_now = 1'b1; wl_en = 1'b1; pl1 = PL_HIGH; pl2 = PL_HIGH; wl_ctx = tgt_q; end
            S_PG_LO:  begin pwr_now = 1'b1; wl_en = 1'b1; wl_ctx = tgt_q; end
            S_PO_PL:  pwr_now = 1'b1;
            default:  ;
        endcase
    end

    assign cell_pwr   = pwr_now;
    assign pl1_lvl    = pl1;
    assign pl2_lvl    = pl2;
    assign active_ctx = act_q;
    assign done       = done_q;
    assign busy       = !(state_q == S_OFF || state_q == S_NORMAL);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r2_power_after_pl1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cell_pwr) |-> (pl1_lvl == PL_HIGH && $past(pl1_lvl) == PL_HIGH && pl2_lvl == PL_LOW && !wl_en));

    a_r6_pl_low_before_cut: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cell_pwr) |-> ($past(pl1_lvl) == PL_LOW && $past(pl2_lvl) == PL_LOW));

    a_r5_wordline_powered: assert property (@(posedge clk) disable iff (!rst_n)
        wl_en |-> cell_pwr);

    a_r4_ctx_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (active_ctx != $past(active_ctx)) |-> done);

endmodule

// File: tb/cfgseq_ctrl_test.sv
module cfgseq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int CTX_W      = 3;
    localparam int CTX_LAT    = 6;
    localparam logic [5:0] V_NORM = 6'b1_0_01_01;
    localparam logic [5:0] V_OFF  = 6'b0_0_00_00;

    logic             clk, rst_n, cmd_valid, supply_ok;
    logic [2:0]       cmd;
    logic [CTX_W-1:0] ctx_id;
    logic             cell_pwr, wl_en, busy, done;
    logic [CTX_W-1:0] wl_ctx, active_ctx;
    logic [1:0]       pl1_lvl, pl2_lvl;
    logic [5:0]       obs;
    logic [CTX_W-1:0] act_model;
    int               checks, errors;

    cfgseq_ctrl #(.CTX_W(CTX_W), .CTX_LAT(CTX_LAT)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .ctx_id(ctx_id),
        .supply_ok(supply_ok), .cell_pwr(cell_pwr), .wl_en(wl_en), .wl_ctx(wl_ctx),
        .pl1_lvl(pl1_lvl), .pl2_lvl(pl2_lvl), .active_ctx(active_ctx),
        .busy(busy), .done(done)
    );

    assign obs = {cell_pwr, wl_en, pl1_lvl, pl2_lvl};

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    function automatic logic [5:0] step_exp(int op, int i);
        case (op)
            2: return 6'b1_1_01_01;
            3: return (i == 0) ? 6'b1_1_10_10 : 6'b1_1_00_00;
            4: return (i == 0) ? V_OFF : ((i == 1) ? 6'b0_0_10_00 : 6'b1_0_10_00);
            5: return (i == 0) ? 6'b1_0_00_00 : V_OFF;
            default: return V_NORM;
        endcase
    endfunction

    function automatic int seq_len(int op);
        case (op)
            2: return CTX_LAT;
            3: return 2;
            4: return 3;
            5: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(int op);
        case (op)
            2: return "R4";
            3: return "R5";
            4: return "R2";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_seq(input int op, input int ctx, input bit via_sup);
        string            rq = req_of(op);
        int               len = seq_len(op);
        logic [CTX_W-1:0] exp_act = (op == 2) ? CTX_W'(ctx) : act_model;
        if (via_sup) supply_ok = (op == 4);
        else begin
            cmd_valid = 1'b1; cmd = 3'(op); ctx_id = CTX_W'(ctx);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < len; i++) begin
            chk(rq, "step levels", obs, step_exp(op, i));
            chk("R8", "busy during step", busy, 1);
            chk("R10", "done during step", done, 0);
            if (op == 2 || op == 3) chk(rq, "wordline context", wl_ctx, ctx);
            if (i == 1) begin
                cmd_valid = 1'b1;
                cmd = ($urandom % 2) ? 3'd2 : 3'd3;
                ctx_id = CTX_W'($urandom);
            end else cmd_valid = 1'b0;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk(rq, "final levels", obs, (op == 5) ? V_OFF : V_NORM);
        chk("R10", "done pulse", done, 1);
        chk("R8", "busy cleared", busy, 0);
        act_model = exp_act;
        chk(rq, "active context", active_ctx, act_model);
        if (op != 5) chk("R3", "normal wl_ctx", wl_ctx, act_model);
        @(negedge clk);
        chk("R10", "done drops", done, 0);
    endtask

    task automatic no_seq(input int op, input int ctx, input string rq, input logic [5:0] lv);
        cmd_valid = 1'b1; cmd = 3'(op); ctx_id = CTX_W'(ctx);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(rq, "levels unchanged", obs, lv);
        chk(rq, "no busy", busy, 0);
        chk(rq, "no done", done, 0);
        chk(rq, "active unchanged", active_ctx, act_model);
        @(negedge clk);
        chk(rq, "still idle", busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int r, c;
        bit via;
        void'($urandom(32'd4711));
        checks = 0; errors = 0; act_model = '0;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd = '0; ctx_id = '0; supply_ok = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset levels", obs, V_OFF);
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset done", done, 0);
        chk("R1", "reset context", active_ctx, 0);
        // commands ignored while unpowered
        no_seq(2, 3, "R9", V_OFF);
        no_seq(3, 6, "R9", V_OFF);
        no_seq(5, 0, "R7", V_OFF);
        // power-up recall from the detector
        run_seq(4, 0, 1'b1);
        chk("R3", "normal levels", obs, V_NORM);
        // context changes at both extremes, then a program
        run_seq(2, 7, 1'b0);
        run_seq(2, 0, 1'b0);
        run_seq(3, 5, 1'b0);
        run_seq(2, 4, 1'b0);
        // codes with no sequence in Normal
        no_seq(0, 1, "R9", V_NORM);
        no_seq(1, 2, "R9", V_NORM);
        no_seq(4, 3, "R9", V_NORM);
        no_seq(6, 5, "R9", V_NORM);
        no_seq(7, 6, "R9", V_NORM);
        // R7 power-off pre-empts a context change in its read window
        cmd_valid = 1'b1; cmd = 3'd2; ctx_id = 3'd5;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R4", "read step", obs, 6'b1_1_01_01);
        @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        chk("R7", "pre-empt first step", obs, 6'b1_0_00_00);
        chk("R7", "pre-empt busy", busy, 1);
        chk("R7", "pre-empt no done", done, 0);
        @(negedge clk);
        chk("R7", "pre-empt cut", obs, V_OFF);
        chk("R7", "pre-empt still busy", busy, 1);
        @(negedge clk);
        chk("R7", "pre-empt off", obs, V_OFF);
        chk("R7", "pre-empt done", done, 1);
        chk("R7", "context kept", active_ctx, act_model);
        @(negedge clk);
        run_seq(4, 0, 1'b1);
        // power-off by command, ignored program while off, recall by command
        run_seq(5, 0, 1'b0);
        no_seq(3, 1, "R9", V_OFF);
        run_seq(4, 0, 1'b0);
        // random phase
        for (int n = 0; n < 400; n++) begin
            r = $urandom % 8;
            c = $urandom % 8;
            case (r)
                2, 3: run_seq(r, c, 1'b0);
                5: begin
                    via = 1'($urandom % 2);
                    run_seq(5, c, via);
                    run_seq(4, 0, via);
                end
                default: no_seq(r, c, "R9", V_NORM);
            endcase
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule